// File: doc/BRIEF.md
# Resolution-Selectable Conversion Sequencer

This block decides when a temperature conversion runs and stores what it produces. It reads a two-bit resolution code, a shutdown bit and a one-shot request from configuration logic. It sends a single-cycle start pulse to an external converter and then waits a number of clocks set by the resolution. The wait doubles for each extra bit of resolution. At the end of the wait it stores the converter's 12-bit two's-complement result in the temperature register. The lower bits that the selected resolution does not use are forced to zero. The LSB of the stored value is 0.0625 °C, so 0x190 means 25 °C and 0xE70 means −25 °C.

A completion pulse goes out in the same cycle that the register changes, for use by downstream alert logic. With shutdown clear, conversions follow one another with no gap. Setting shutdown lets the conversion in flight finish and then stops the sequence. While the block is stopped, a one-shot request runs exactly one conversion.

Top module: `conv_sequencer`

## Requirements
- R1: While reset is asserted, and after reset until the first completion, `temp_value` is 0 and `conv_start` and `conv_done` are low.
- R2: With `cfg_shutdown` low, a new `conv_start` pulse comes in the same cycle as each `conv_done`. The first pulse comes one clock after reset is released, so there are no idle cycles between conversions.
- R3: `conv_done` goes high exactly BASE_CYCLES << `cfg_res` clocks after the matching `conv_start` (code 0 = 9 bits, 1 = 10 bits, 2 = 11 bits, 3 = 12 bits).
- R4: The resolution code is sampled in the cycle a conversion starts. Changing `cfg_res` during a conversion has no effect on that conversion's length or masking.
- R5: The stored result keeps its upper 9 + code bits. Its lowest 3 − code bits read as zero (for example 0xFFF stores as 0xFF8 at code 0, 0xFFC at code 1, 0xFFE at code 2, 0xFFF at code 3).
- R6: The value stored is `conv_result` as presented in the last clock of the conversion. Two's-complement values such as 0xE70 are stored unchanged apart from the masking in R5.
- R7: `conv_done` is a one-clock pulse. `temp_value` changes only on the edge that raises `conv_done` and holds its value at all other times.
- R8: If `cfg_shutdown` is high on the edge where a conversion finishes, that conversion still completes and stores its result. After that, no `conv_start` occurs while shutdown stays high and no one-shot arrives.
- R9: While stopped with `cfg_shutdown` high, a one-clock `oneshot_req` produces exactly one `conv_start` and one `conv_done`, and the block then stays stopped.
- R10: `oneshot_req` is ignored in any cycle where a conversion is running, including its final cycle, and whenever shutdown is low. It causes no extra start and does not change the conversion timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_res | input | 2 | Resolution code, 0 = 9 bits ... 3 = 12 bits |
| cfg_shutdown | input | 1 | 1 stops conversions after the current one |
| oneshot_req | input | 1 | Single-conversion request, honoured only when stopped |
| conv_start | output | 1 | One-clock start pulse to the converter |
| conv_result | input | TEMP_W | Converter output, two's complement |
| conv_done | output | 1 | One-clock pulse when `temp_value` updates |
| temp_value | output | TEMP_W | Stored, masked temperature |

## Verification
The hardest situation to reach is the edge where a conversion finishes at the same moment shutdown rises, a one-shot arrives, or the resolution changes. Each of these inputs has a different effect depending on which cycle it lands in. The directed part of the bench synchronises on `conv_done` and then changes inputs a fixed number of clocks later, so that it hits the middle of a conversion. The random part toggles shutdown, one-shot and resolution at rates low enough that all three often land on a finishing edge over several thousand cycles. A cycle-level reference model in the bench follows every start, completion and stored value.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int RES_W = 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_e;

endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
    parameter int BASE_CYCLES = 4,
    parameter int CNT_W       = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_i,
    input  logic [conv_seq_pkg::RES_W-1:0] res_i,
    output logic                           last_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.cnt = (CNT_W'(BASE_CYCLES) << res_i) - CNT_W'(1);
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign last_o = (cur_q.cnt == '0);

endmodule

// File: rtl/conv_capture.sv
module conv_capture #(
    parameter int TEMP_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           capture_i,
    input  logic [conv_seq_pkg::RES_W-1:0] res_i,
    input  logic [TEMP_W-1:0]              raw_i,
    output logic [TEMP_W-1:0]              temp_o
);

    localparam int DROP_MAX = 3;

    typedef struct packed {
        logic [TEMP_W-1:0] temp;
    } cap_t;

    cap_t cur_q, nxt_d;
    logic [TEMP_W-1:0] keep_mask;

    always_comb begin
        keep_mask = {TEMP_W{1'b1}} << (2'(DROP_MAX) - res_i);
        nxt_d = cur_q;
        if (capture_i) begin
            nxt_d.temp = raw_i & keep_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign temp_o = cur_q.temp;

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && res_i == 2'd0) |=> (temp_o[2:0] == 3'b000)); // R5

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (temp_o[TEMP_W-1:3] == $past(raw_i[TEMP_W-1:3]))); // R6

    AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(temp_o)); // R7

endmodule

// File: rtl/conv_ctrl.sv
module conv_ctrl
    import conv_seq_pkg::*;
#(
    parameter int BASE_CYCLES = 4,
    parameter int CNT_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] cfg_res_i,
    input  logic             shutdown_i,
    input  logic             oneshot_i,
    input  logic             timer_last_i,
    output logic             load_o,
    output logic             capture_o,
    output logic [RES_W-1:0] res_lat_o,
    output logic             start_o,
    output logic             done_o
);

    typedef struct packed {
        seq_state_e       state;
        logic             start;
        logic             done;
        logic [RES_W-1:0] res;
        logic [CNT_W-1:0] since;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  finish;
    logic  go;

    always_comb begin
        finish = (cur_q.state == ST_CONV) && timer_last_i;
        go     = ((cur_q.state == ST_IDLE) && (!shutdown_i || oneshot_i))
              || (finish && !shutdown_i);

        nxt_d       = cur_q;
        nxt_d.start = go;
        nxt_d.done  = finish;
        if (go) begin
            nxt_d.state = ST_CONV;
            nxt_d.res   = cfg_res_i;
            nxt_d.since = CNT_W'(1);
        end else if (finish) begin
            nxt_d.state = ST_IDLE;
        end else if (cur_q.state == ST_CONV) begin
            nxt_d.since = cur_q.since + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, start: 1'b0, done: 1'b0, res: '0, since: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign load_o    = go;
    assign capture_o = finish;
    assign res_lat_o = cur_q.res;
    assign start_o   = cur_q.start;
    assign done_o    = cur_q.done;

    AST_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == ST_CONV) && timer_last_i)
            |-> (cur_q.since == (CNT_W'(BASE_CYCLES) << cur_q.res))); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == ST_IDLE) && shutdown_i && !oneshot_i) |=> !start_o); // R8

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == ST_CONV) && !timer_last_i) |=> !start_o); // R10

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
    parameter int BASE_CYCLES = 4,
    parameter int TEMP_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_res,
    input  logic              cfg_shutdown,
    input  logic              oneshot_req,
    output logic              conv_start,
    input  logic [TEMP_W-1:0] conv_result,
    output logic              conv_done,
    output logic [TEMP_W-1:0] temp_value
);

    localparam int MAX_CYCLES = BASE_CYCLES << 3;
    localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

    logic       load;
    logic       capture;
    logic       timer_last;
    logic [1:0] res_lat;

    conv_ctrl #(
        .BASE_CYCLES(BASE_CYCLES),
        .CNT_W      (CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_res_i   (cfg_res),
        .shutdown_i  (cfg_shutdown),
        .oneshot_i   (oneshot_req),
        .timer_last_i(timer_last),
        .load_o      (load),
        .capture_o   (capture),
        .res_lat_o   (res_lat),
        .start_o     (conv_start),
        .done_o      (conv_done)
    );

    conv_timer #(
        .BASE_CYCLES(BASE_CYCLES),
        .CNT_W      (CNT_W)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .res_i (cfg_res),
        .last_o(timer_last)
    );

    conv_capture #(
        .TEMP_W(TEMP_W)
    ) capture_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture_i(capture),
        .res_i    (res_lat),
        .raw_i    (conv_result),
        .temp_o   (temp_value)
    );

    AST_DONE_UPDATES_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(temp_value) |-> conv_done); // R7

endmodule

// File: tb/conv_sequencer_tb_top.sv
module conv_sequencer_tb_top;

    localparam int CLK_P  = 10;
    localparam int BASE   = 4;
    localparam int TW     = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_res = 2'd0;
    logic          cfg_shutdown = 1'b0;
    logic          oneshot_req = 1'b0;
    logic [TW-1:0] conv_result = '0;
    logic          conv_start;
    logic          conv_done;
    logic [TW-1:0] temp_value;

    int n_checks = 0;
    int n_fail   = 0;
    int starts_seen = 0;
    int dones_seen  = 0;
    bit finished = 1'b0;

    bit            m_busy = 1'b0;
    int            m_cnt  = 0;
    logic [1:0]    m_res  = 2'd0;
    logic [TW-1:0] m_prev_temp = '0;

    always #(CLK_P/2) clk = ~clk;

    conv_sequencer #(.BASE_CYCLES(BASE), .TEMP_W(TW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_res     (cfg_res),
        .cfg_shutdown(cfg_shutdown),
        .oneshot_req (oneshot_req),
        .conv_start  (conv_start),
        .conv_result (conv_result),
        .conv_done   (conv_done),
        .temp_value  (temp_value)
    );

    function automatic int conv_len(logic [1:0] r);
        return BASE << r;
    endfunction

    function automatic logic [TW-1:0] masked(logic [TW-1:0] v, logic [1:0] r);
        return v & ({TW{1'b1}} << (3 - r));
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Reference model: samples at the falling edge, before the driver moves inputs
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(conv_start == 1'b0, "R1 start in reset", 32'(conv_start), 0);
            chk(conv_done == 1'b0, "R1 done in reset", 32'(conv_done), 0);
            chk(temp_value == '0, "R1 temp in reset", 32'(temp_value), 0);
            m_busy = 1'b0;
            m_cnt = 0;
            m_prev_temp = '0;
        end else begin
            bit done_exp;
            bit start_exp;
            string tag;
            if (m_busy) m_cnt++;
            done_exp = m_busy && (m_cnt == conv_len(m_res));
            chk(conv_done == done_exp, "R3 R4 done timing", 32'(conv_done), 32'(done_exp));
            if (m_busy) begin
                start_exp = done_exp && !cfg_shutdown;
                tag = !done_exp ? "R10 no start while busy"
                                : (cfg_shutdown ? "R8 stop after finish" : "R2 back to back");
            end else begin
                start_exp = !cfg_shutdown || oneshot_req;
                tag = !cfg_shutdown ? "R2 start when running"
                                    : (oneshot_req ? "R9 one-shot start" : "R8 stay stopped");
            end
            chk(conv_start == start_exp, tag, 32'(conv_start), 32'(start_exp));
            if (done_exp) begin
                chk(temp_value == masked(conv_result, m_res), "R5 R6 stored value",
                    32'(temp_value), 32'(masked(conv_result, m_res)));
            end else begin
                chk(temp_value == m_prev_temp, "R1 R7 temp held", 32'(temp_value), 32'(m_prev_temp));
            end
            if (conv_start) starts_seen++;
            if (conv_done) dones_seen++;
            m_prev_temp = temp_value;
            if (start_exp) begin
                m_busy = 1'b1;
                m_cnt = 0;
                m_res = cfg_res;
            end else if (done_exp) begin
                m_busy = 1'b0;
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (conv_done !== 1'b1);
        #1;
    endtask

    initial begin
        int seed;
        int s0;
        int d0;
        seed = 7321;
        void'($urandom(seed));

        tick(4);
        rst_n = 1'b1;

        // R4/R5/R6 directed: 12-bit conversion then a mid-flight code change
        cfg_res = 2'd3;
        conv_result = 12'h190;
        wait_done();
        chk(temp_value == 12'h190, "R6 25C value", 32'(temp_value), 32'h190);
        conv_result = 12'hFFF;
        tick(5);
        cfg_res = 2'd0;
        wait_done();
        chk(temp_value == 12'hFFF, "R4 latched code 3", 32'(temp_value), 32'hFFF);
        wait_done();
        chk(temp_value == 12'hFF8, "R5 code 0 mask", 32'(temp_value), 32'hFF8);
        cfg_res = 2'd1;
        wait_done();
        wait_done();
        chk(temp_value == 12'hFFC, "R5 code 1 mask", 32'(temp_value), 32'hFFC);
        cfg_res = 2'd2;
        wait_done();
        wait_done();
        chk(temp_value == 12'hFFE, "R5 code 2 mask", 32'(temp_value), 32'hFFE);
        cfg_res = 2'd0;
        conv_result = 12'hE70;
        wait_done();
        wait_done();
        chk(temp_value == 12'hE70, "R6 negative value", 32'(temp_value), 32'hE70);

        // R10: one-shots during running conversions add no starts (code 2: 16 clocks)
        cfg_res = 2'd2;
        wait_done();
        wait_done();
        s0 = starts_seen;
        for (int i = 0; i < 10; i++) begin
            tick(3);
            oneshot_req = 1'b1;
            tick(1);
            oneshot_req = 1'b0;
            tick(12);
        end
        chk(starts_seen - s0 == 10, "R10 start count", 32'(starts_seen - s0), 32'd10);

        // R8: shutdown mid conversion lets it finish, then stops
        wait_done();
        tick(6);
        cfg_shutdown = 1'b1;
        s0 = starts_seen;
        d0 = dones_seen;
        tick(300);
        chk(dones_seen - d0 == 1, "R8 in-flight finished", 32'(dones_seen - d0), 32'd1);
        chk(starts_seen - s0 == 0, "R8 no new start", 32'(starts_seen - s0), 32'd0);

        // R9: one-shot from shutdown runs once
        conv_result = 12'h4B7;
        cfg_res = 2'd1;
        s0 = starts_seen;
        d0 = dones_seen;
        oneshot_req = 1'b1;
        tick(1);
        oneshot_req = 1'b0;
        tick(300);
        chk(starts_seen - s0 == 1, "R9 single start", 32'(starts_seen - s0), 32'd1);
        chk(dones_seen - d0 == 1, "R9 single done", 32'(dones_seen - d0), 32'd1);
        chk(temp_value == 12'h4B4, "R9 R5 one-shot value", 32'(temp_value), 32'h4B4);

        // Random phase
        for (int i = 0; i < 8000; i++) begin
            conv_result = TW'($urandom);
            if ($urandom_range(63) == 0) cfg_shutdown = ~cfg_shutdown;
            if ($urandom_range(31) == 0) cfg_res = 2'($urandom);
            oneshot_req = ($urandom_range(15) == 0);
            tick(1);
        end

        // Reset again mid-run: R1
        rst_n = 1'b0;
        tick(2);
        chk(temp_value == '0, "R1 temp cleared", 32'(temp_value), 0);
        rst_n = 1'b1;
        cfg_shutdown = 1'b0;
        tick(50);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule